// File: doc/BRIEF.md
# Block Lock Protection Unit

This unit keeps the write-protection state of every erase block in a 4-Mword boot-block flash array with a bottom-boot layout. Eight small 4-Kword parameter blocks sit at the lowest addresses and 127 large 32-Kword main blocks follow them, for 135 blocks in all. A word address is reduced to a block index, and each block carries two state bits: a locked flag and a locked-down flag.

The command sequencer presents one lock, unlock or lock-down request per clock, with an address inside the target block. A hardware guard pin decides whether locked-down blocks are frozen (pin low) or may still be locked and unlocked by software (pin high). On a separate query port the unit reports, with no clock delay, whether a program or erase to the queried address is permitted. It also returns the lock status word for a signature read and flags whether the queried address is the status offset of its block. The sequencer uses a denied access to abort the operation and raise its protection error status bit.

Top module: `blk_lock_unit`

## Requirements
- R1: While reset is held low, and after it is released, every block is locked and no block is locked-down.
- R2: An address below 008000h selects parameter block address[14:12] (eight blocks of 4 Kwords). Any higher address selects block 7 + address[21:15] (127 blocks of 32 Kwords, indices 8 to 134).
- R3: `query_allow` is 1 exactly when the block holding `query_addr` is unlocked.
- R4: A command has the code 00 for lock (sets the locked flag) and 01 for unlock (clears it). The code 11 and cycles with `cmd_valid` low change nothing.
- R5: Lock-down (code 10) sets the locked-down flag of the block and also sets its locked flag, unless the block is frozen.
- R6: A block is frozen when its locked-down flag is 1 and `guard_pin` is 0. Lock and unlock requests to a frozen block are ignored.
- R7: While `guard_pin` is 1, a locked-down block can be locked and unlocked and keeps its locked-down flag. When the pin returns to 0, it is frozen at the locked value it then holds.
- R8: Once set, a locked-down flag is cleared only by reset.
- R9: `stat_word` bit 0 is the locked flag and bit 1 the locked-down flag of the queried block; all other bits are 0. `sig_hit` is 1 when the offset of `query_addr` within its block equals 2.
- R10: A query in the same cycle as a command to that block sees the state held before that cycle. The change is visible after the next rising clock edge.
- R11: A command changes only the block that its address selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| guard_pin | input | 1 | 0 freezes locked-down blocks, 1 lets software change them |
| cmd_valid | input | 1 | A protection command is present this cycle |
| cmd_op | input | 2 | 00 lock, 01 unlock, 10 lock-down, 11 no operation |
| cmd_addr | input | 22 | Any word address inside the target block |
| query_addr | input | 22 | Word address being checked |
| query_allow | output | 1 | Program or erase at query_addr is permitted |
| stat_word | output | 16 | Lock status word of the queried block |
| sig_hit | output | 1 | query_addr is at offset 2 within its block |

## Verification
The hardest state to reach is a locked-down block that is unlocked yet frozen. It exists only after this sequence: a lock-down with the guard pin low, the pin raised, an unlock, and the pin lowered again. The bench walks that sequence on one main block. It then shows that lock and unlock both bounce off while program access stays allowed, and that only a reset pulse clears the locked-down flag. Block boundaries on both sides of the parameter-to-main transition and at the top of the array are probed, so that an indexing slip shows up as a neighbour's state changing.

// File: rtl/blk_lock_unit.sv
module blk_lock_unit #(
  parameter int ADDR_W      = 22,
  parameter int PARAM_SHIFT = 12,
  parameter int MAIN_SHIFT  = 15,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              guard_pin,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] query_addr,
  output logic              query_allow,
  output logic [WORD_W-1:0] stat_word,
  output logic              sig_hit
);
  localparam int N_PARAM = 1 << (MAIN_SHIFT - PARAM_SHIFT);
  localparam int N_MAIN  = (1 << (ADDR_W - MAIN_SHIFT)) - 1;
  localparam int N_BLK   = N_PARAM + N_MAIN;
  localparam int IDX_W   = $clog2(N_BLK);

  localparam logic [1:0] OP_LOCK   = 2'b00;
  localparam logic [1:0] OP_UNLOCK = 2'b01;
  localparam logic [1:0] OP_DOWN   = 2'b10;

  function automatic logic in_param(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:MAIN_SHIFT] == '0;
  endfunction

  function automatic logic [IDX_W-1:0] blk_of(input logic [ADDR_W-1:0] a);
    if (in_param(a)) return IDX_W'(a[MAIN_SHIFT-1:PARAM_SHIFT]);
    return IDX_W'(N_PARAM - 1) + IDX_W'(a[ADDR_W-1:MAIN_SHIFT]);
  endfunction

  logic [N_BLK-1:0] lk, ld;
  logic [IDX_W-1:0] ci, qi;
  logic             frz;

  assign ci  = blk_of(cmd_addr);
  assign qi  = blk_of(query_addr);
  assign frz = ld[ci] & ~guard_pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk <= '1;
      ld <= '0;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_LOCK:   if (!frz) lk[ci] <= 1'b1;
        OP_UNLOCK: if (!frz) lk[ci] <= 1'b0;
        OP_DOWN: begin
          ld[ci] <= 1'b1;
          if (!frz) lk[ci] <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign query_allow = ~lk[qi];
  assign stat_word   = WORD_W'({ld[qi], lk[qi]});
  assign sig_hit     = in_param(query_addr)
                     ? (query_addr[PARAM_SHIFT-1:0] == PARAM_SHIFT'(2))
                     : (query_addr[MAIN_SHIFT-1:0]  == MAIN_SHIFT'(2));

  p_lock_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_LOCK && !frz |=> lk[$past(ci)]);

  p_down_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op == OP_DOWN |=> ld[$past(ci)]);

  p_frozen_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_op != OP_DOWN && ld[ci] && !guard_pin
    |=> lk[$past(ci)] == $past(lk[ci]));

  p_down_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ld & $past(ld)) == $past(ld));

  p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(lk) && $stable(ld));
endmodule

// File: tb/blk_lock_unit_tb_top.sv
module blk_lock_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        guard_pin = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'b11;
  logic [21:0] cmd_addr = '0;
  logic [21:0] query_addr = '0;
  logic        query_allow;
  logic [15:0] stat_word;
  logic        sig_hit;
  int          n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  blk_lock_unit dut_i (
    .clk(clk), .rst_n(rst_n), .guard_pin(guard_pin), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .query_addr(query_addr),
    .query_allow(query_allow), .stat_word(stat_word), .sig_hit(sig_hit)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [1:0] op, input logic [21:0] a);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
  endtask

  task automatic probe(input string req, input logic [21:0] a,
                       input logic allow, input logic [15:0] word);
    query_addr = a;
    #1;
    chk(req, 16'(query_allow), 16'(allow));
    chk(req, stat_word, word);
  endtask

  task automatic t_reset;
    probe("R1 blk0", 22'h000000, 1'b0, 16'h0001);
    probe("R1 blk7", 22'h007FFF, 1'b0, 16'h0001);
    probe("R1 blk8", 22'h008000, 1'b0, 16'h0001);
    probe("R1 blk134", 22'h3FFFFF, 1'b0, 16'h0001);
  endtask

  task automatic t_decode;
    cmd(2'b01, 22'h001234);
    probe("R2 R3 param1 unlocked", 22'h001FFF, 1'b1, 16'h0000);
    probe("R11 param0 untouched", 22'h000FFF, 1'b0, 16'h0001);
    probe("R11 param2 untouched", 22'h002000, 1'b0, 16'h0001);
    cmd(2'b01, 22'h3F8123);
    probe("R2 blk134 unlocked", 22'h3FFFFF, 1'b1, 16'h0000);
    probe("R11 blk133 untouched", 22'h3F7FFF, 1'b0, 16'h0001);
    cmd(2'b01, 22'h008000);
    probe("R2 blk8 unlocked", 22'h00FFFF, 1'b1, 16'h0000);
    probe("R2 blk7 untouched", 22'h007FFF, 1'b0, 16'h0001);
  endtask

  task automatic t_lock;
    cmd(2'b00, 22'h001000);
    probe("R4 relock param1", 22'h001000, 1'b0, 16'h0001);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b11; cmd_addr = 22'h002000;
    @(negedge clk);
    cmd_valid = 1'b0;
    probe("R4 nop code", 22'h002000, 1'b0, 16'h0001);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b01; cmd_addr = 22'h002000;
    @(negedge clk);
    cmd_op = 2'b11;
    probe("R4 valid low ignored", 22'h002000, 1'b0, 16'h0001);
  endtask

  task automatic t_sig;
    query_addr = 22'h001002; #1; chk("R9 param offset2", 16'(sig_hit), 16'd1);
    query_addr = 22'h001003; #1; chk("R9 param offset3", 16'(sig_hit), 16'd0);
    query_addr = 22'h010002; #1; chk("R9 main offset2", 16'(sig_hit), 16'd1);
    query_addr = 22'h011002; #1; chk("R9 main offset1002", 16'(sig_hit), 16'd0);
  endtask

  task automatic t_down;
    guard_pin = 1'b0;
    cmd(2'b10, 22'h010000);
    probe("R5 lockdown", 22'h010000, 1'b0, 16'h0003);
    cmd(2'b01, 22'h010000);
    probe("R6 unlock frozen ignored", 22'h010000, 1'b0, 16'h0003);
  endtask

  task automatic t_guard;
    guard_pin = 1'b1;
    cmd(2'b01, 22'h010000);
    probe("R7 unlock with pin high", 22'h010000, 1'b1, 16'h0002);
    guard_pin = 1'b0;
    cmd(2'b00, 22'h010000);
    probe("R7 R6 frozen unlocked", 22'h010000, 1'b1, 16'h0002);
    guard_pin = 1'b1;
    cmd(2'b00, 22'h010000);
    probe("R7 lock with pin high", 22'h010000, 1'b0, 16'h0003);
    guard_pin = 1'b0;
  endtask

  task automatic t_same;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_addr = 22'h068000;
    query_addr = 22'h068000;
    #1;
    chk("R10 old state same cycle", 16'(query_allow), 16'd0);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_op = 2'b11;
    #1;
    chk("R10 new state after edge", 16'(query_allow), 16'd1);
  endtask

  task automatic t_rst;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    probe("R8 lockdown cleared by reset", 22'h010000, 1'b0, 16'h0001);
    probe("R1 relocked after reset", 22'h068000, 1'b0, 16'h0001);
  endtask

  bit done = 0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_decode(); t_lock(); t_sig();
    t_down(); t_guard(); t_same(); t_rst();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule